// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the operand address for the data-transfer instructions of a 32-bit processor whose instructions are all 16 bits long. The decoder hands it a request strobe together with an addressing mode, an operand size, the value of the base register, the current program counter and an 8-bit displacement field. One cycle later the unit presents the effective address. It also presents a flag for register-direct operands and an alignment-fault flag. For post-increment accesses it produces the updated base value and a write-back enable, one cycle after that.

A 16-bit instruction can only carry a byte constant as immediate data. Word and longword constants, absolute addresses and wide displacements are therefore kept in a table near the code. They are reached with the PC-relative mode: the displacement is zero-extended and scaled by the operand size, then added to the program counter plus four. For longword table entries the base is first rounded down to a multiple of four, so that the fetch is always aligned.

Top module: `eau_unit`

## Requirements
- R1: A synchronous reset drives every output (ea_valid, ea, reg_operand, addr_err, wb_en, wb_data) to zero, and a request presented while reset is high produces no result.
- R2: ea_valid is high in the cycle after each clock edge at which req_valid was high, and low after an edge at which req_valid was low.
- R3: Mode code 00 (register direct) gives reg_operand=1, ea=0 and addr_err=0, and no write-back follows.
- R4: Mode code 01 (register indirect) gives ea equal to base, with reg_operand=0 and no write-back.
- R5: Mode code 10 (post-increment) gives ea equal to base. In the cycle after ea_valid, wb_en is high and wb_data is base plus 1, 2 or 4 for size codes 00 (byte), 01 (word) and 10 (longword).
- R6: Mode code 11 (PC-relative) with a byte or word size gives ea = pc + 4 + zero-extended disp × 1 (byte) or × 2 (word).
- R7: Mode code 11 with a longword size gives ea = ((pc + 4) with its two low bits cleared) + disp × 4.
- R8: In the memory modes (01, 10, 11), addr_err is high when a word address has bit 0 set or when a longword address has a nonzero value in bits 1:0. A byte address never faults.
- R9: A post-increment access that raises addr_err produces no write-back: wb_en stays low in the following cycle.
- R10: Size code 11 is handled exactly as a longword (step 4, ×4 scaling, 4-byte alignment).
- R11: wb_en is never high except in the cycle after a post-increment result; indirect, direct and PC-relative accesses leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one address per cycle |
| mode | input | 2 | Addressing mode: 00 direct, 01 indirect, 10 post-increment, 11 PC-relative |
| size | input | 2 | Operand size: 00 byte, 01 word, 10 longword, 11 treated as longword |
| base | input | AW (32) | Current value of the base register |
| pc | input | AW (32) | Program counter of the instruction |
| disp | input | DISPW (8) | Unsigned displacement field |
| ea_valid | output | 1 | Result valid, one cycle after the request |
| ea | output | AW (32) | Effective address (zero for register direct) |
| reg_operand | output | 1 | Operand is the register itself |
| addr_err | output | 1 | Misaligned word or longword address |
| wb_en | output | 1 | Base register write-back enable |
| wb_data | output | AW (32) | New base register value |

## Verification
A wrong size decode shows up at the ports in two places. It gives the wrong post-increment step in wb_data two cycles after the request, and the wrong PC-relative scaling or alignment fault in ea one cycle after it. The bench therefore sweeps every size code through both modes. A stale write-back pipeline register shows up as a wb_en pulse after a non-post-increment request or after a faulting one. Any wrong mode or fault state is visible in the very next result cycle. Back-to-back requests are mixed so that a pipeline stage carrying one request's data into its neighbour is caught.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [1:0] {
    MODE_REG   = 2'b00,
    MODE_IND   = 2'b01,
    MODE_POST  = 2'b10,
    MODE_PCREL = 2'b11
  } eau_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } eau_size_e;

  // log2 of the operand width in bytes; the reserved code acts as a longword
  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    case (eau_size_e'(sz))
      SZ_BYTE: size_shift = 2'd0;
      SZ_WORD: size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/eau_size_dec.sv
module eau_size_dec
  import eau_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [1:0]    size,
  output logic [1:0]    shift,
  output logic [AW-1:0] step,
  output logic [1:0]    align_mask
);

  always_comb begin
    shift = size_shift(size);
    step  = AW'(1) << shift;
    case (shift)
      2'd0:    align_mask = 2'b00;
      2'd1:    align_mask = 2'b01;
      default: align_mask = 2'b11;
    endcase
  end

endmodule

// File: rtl/eau_addr_gen.sv
module eau_addr_gen
  import eau_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISPW  = 8,
  parameter int PC_OFS = 4
) (
  input  logic [1:0]       mode,
  input  logic [1:0]       shift,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    pc,
  input  logic [DISPW-1:0] disp,
  output logic [AW-1:0]    ea,
  output logic             is_reg,
  output logic             is_post
);

  localparam int PADW = AW - DISPW;

  logic [AW-1:0] pc_ahead;
  logic [AW-1:0] pc_base;
  logic [AW-1:0] disp_ext;
  logic [AW-1:0] disp_scaled;

  always_comb begin
    pc_ahead    = pc + AW'(PC_OFS);
    pc_base     = (shift == 2'd2) ? {pc_ahead[AW-1:2], 2'b00} : pc_ahead;
    disp_ext    = {{PADW{1'b0}}, disp};
    disp_scaled = disp_ext << shift;
  end

  always_comb begin
    is_reg  = 1'b0;
    is_post = 1'b0;
    case (eau_mode_e'(mode))
      MODE_REG: begin
        ea     = '0;
        is_reg = 1'b1;
      end
      MODE_IND: ea = base;
      MODE_POST: begin
        ea      = base;
        is_post = 1'b1;
      end
      default: ea = pc_base + disp_scaled;
    endcase
  end

endmodule

// File: rtl/eau_align_chk.sv
module eau_align_chk #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ea,
  input  logic [1:0]    align_mask,
  input  logic          is_reg,
  output logic          misaligned
);

  logic [1:0] bad_bits;

  for (genvar b = 0; b < 2; b++) begin : g_bit
    assign bad_bits[b] = ea[b] & align_mask[b];
  end

  assign misaligned = ~is_reg & (|bad_bits);

endmodule

// File: rtl/eau_unit.sv
module eau_unit
  import eau_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISPW  = 8,
  parameter int PC_OFS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       mode,
  input  logic [1:0]       size,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    pc,
  input  logic [DISPW-1:0] disp,
  output logic             ea_valid,
  output logic [AW-1:0]    ea,
  output logic             reg_operand,
  output logic             addr_err,
  output logic             wb_en,
  output logic [AW-1:0]    wb_data
);

  logic [1:0]    shift;
  logic [AW-1:0] step;
  logic [1:0]    align_mask;
  logic [AW-1:0] ea_nxt;
  logic          is_reg;
  logic          is_post;
  logic          misaligned;

  // stage-1 copy of the write-back, released one cycle after the address
  logic          wb_pend;
  logic [AW-1:0] wb_pend_data;

  eau_size_dec #(.AW(AW)) u_size (
    .size       (size),
    .shift      (shift),
    .step       (step),
    .align_mask (align_mask)
  );

  eau_addr_gen #(.AW(AW), .DISPW(DISPW), .PC_OFS(PC_OFS)) u_gen (
    .mode    (mode),
    .shift   (shift),
    .base    (base),
    .pc      (pc),
    .disp    (disp),
    .ea      (ea_nxt),
    .is_reg  (is_reg),
    .is_post (is_post)
  );

  eau_align_chk #(.AW(AW)) u_align (
    .ea         (ea_nxt),
    .align_mask (align_mask),
    .is_reg     (is_reg),
    .misaligned (misaligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid     <= 1'b0;
      ea           <= '0;
      reg_operand  <= 1'b0;
      addr_err     <= 1'b0;
      wb_pend      <= 1'b0;
      wb_pend_data <= '0;
    end else begin
      ea_valid <= req_valid;
      wb_pend  <= req_valid & is_post & ~misaligned;
      if (req_valid) begin
        ea           <= ea_nxt;
        reg_operand  <= is_reg;
        addr_err     <= misaligned;
        wb_pend_data <= base + step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_data <= '0;
    end else begin
      wb_en <= wb_pend;
      if (wb_pend) wb_data <= wb_pend_data;
    end
  end

endmodule

// File: rtl/eau_unit_chk.sv
module eau_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    mode,
  input logic [1:0]    size,
  input logic          ea_valid,
  input logic [AW-1:0] ea,
  input logic          reg_operand,
  input logic          addr_err,
  input logic          wb_en,
  input logic [AW-1:0] wb_data
);

  function automatic logic [AW-1:0] incr_of(input logic [1:0] s);
    if (s == 2'b00)      incr_of = AW'(1);
    else if (s == 2'b01) incr_of = AW'(2);
    else                 incr_of = AW'(4);
  endfunction

  assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> $past(req_valid));

  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !ea_valid);

  assert_direct_no_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && reg_operand) |-> !addr_err);

  assert_wb_only_postinc_R11: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ($past(ea_valid) && $past(mode, 2) == 2'b10));

  assert_wb_step_R5: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data == $past(ea) + incr_of($past(size, 2))));

  assert_long_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && !reg_operand && !addr_err && $past(size[1])) |-> (ea[1:0] == 2'b00));

  assert_fault_no_wb_R9: assert property (@(posedge clk) disable iff (rst)
    (ea_valid && addr_err) |=> !wb_en);

endmodule

bind eau_unit eau_unit_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .mode        (mode),
  .size        (size),
  .ea_valid    (ea_valid),
  .ea          (ea),
  .reg_operand (reg_operand),
  .addr_err    (addr_err),
  .wb_en       (wb_en),
  .wb_data     (wb_data)
);

// File: tb/eau_unit_tb.sv
module eau_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  size = 2'b00;
  logic [31:0] base = '0;
  logic [31:0] pc = '0;
  logic [7:0]  disp = '0;
  logic        ea_valid;
  logic [31:0] ea;
  logic        reg_operand;
  logic        addr_err;
  logic        wb_en;
  logic [31:0] wb_data;

  int vectors = 0;
  int miscompares = 0;

  typedef struct packed {
    logic [31:0] ea;
    logic        isreg;
    logic        err;
    logic        wb;
    logic [31:0] wbd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  eau_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .size(size),
    .base(base), .pc(pc), .disp(disp), .ea_valid(ea_valid), .ea(ea),
    .reg_operand(reg_operand), .addr_err(addr_err), .wb_en(wb_en), .wb_data(wb_data)
  );

  function automatic exp_t model(input logic [1:0] m, input logic [1:0] s,
                                 input logic [31:0] b, input logic [31:0] p,
                                 input logic [7:0] d);
    exp_t        e;
    int          sh;
    logic [31:0] pb;
    e  = '0;
    sh = (s == 2'b00) ? 0 : (s == 2'b01) ? 1 : 2;
    case (m)
      2'b00: e.isreg = 1'b1;
      2'b01: e.ea = b;
      2'b10: e.ea = b;
      default: begin
        pb = p + 32'd4;
        if (sh == 2) pb[1:0] = 2'b00;
        e.ea = pb + ({24'd0, d} << sh);
      end
    endcase
    if (!e.isreg)
      e.err = (sh == 1 && e.ea[0]) || (sh == 2 && e.ea[1:0] != 2'b00);
    e.wb  = (m == 2'b10) && !e.err;
    e.wbd = b + (32'd1 << sh);
    return e;
  endfunction

  task automatic apply(input logic [1:0] m, input logic [1:0] s, input logic [31:0] b,
                       input logic [31:0] p, input logic [7:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    mode = m; size = s; base = b; pc = p; disp = d;
    exp_q.push_back(model(m, s, b, p, d));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      mode = 2'b10; base = 32'hFFFF_FFF0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // monitor: sample 1 ns after each rising edge
  logic        pend_wb = 1'b0;
  logic [31:0] pend_data = '0;
  string       pend_tag = "";
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        pend_wb = 1'b0;
      end else begin
        check((wb_en === pend_wb) && (!pend_wb || wb_data === pend_data),
              {pend_tag, " write-back"}, pend_wb ? wb_data : {31'd0, wb_en},
              pend_wb ? pend_data : 32'd0);
        if (exp_q.size() > 0) begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ea_valid === 1'b1, {t, " valid R2"}, {31'd0, ea_valid}, 32'd1);
          check(ea === e.ea && reg_operand === e.isreg && addr_err === e.err,
                t, {ea[29:0], reg_operand, addr_err}, {e.ea[29:0], e.isreg, e.err});
          pend_wb   = e.wb;
          pend_data = e.wbd;
          pend_tag  = t;
        end else begin
          check(ea_valid === 1'b0, "R2 idle valid", {31'd0, ea_valid}, 32'd0);
          pend_wb  = 1'b0;
          pend_tag = "R11 idle";
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({ea_valid, reg_operand, addr_err, wb_en} === 4'b0 && ea === 0 && wb_data === 0,
          "R1 reset state", ea, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3 direct
    apply(2'b00, 2'b10, 32'h1234_5678, 32'h100, 8'h3, "R3 direct long");
    apply(2'b00, 2'b01, 32'h0000_0001, 32'h100, 8'h3, "R3 direct word");
    // R4 indirect, with R8 faults
    apply(2'b01, 2'b00, 32'h2000_0003, 32'h0, 8'h0, "R4 indirect byte odd");
    apply(2'b01, 2'b01, 32'h2000_0002, 32'h0, 8'h0, "R4 indirect word");
    apply(2'b01, 2'b01, 32'h2000_0001, 32'h0, 8'h0, "R8 indirect word odd");
    apply(2'b01, 2'b10, 32'h2000_0002, 32'h0, 8'h0, "R8 indirect long misaligned");
    idle(2);
    // R5 post-increment, each size, back to back
    apply(2'b10, 2'b00, 32'h3000_0007, 32'h0, 8'h0, "R5 postinc byte");
    apply(2'b10, 2'b01, 32'h3000_0010, 32'h0, 8'h0, "R5 postinc word");
    apply(2'b10, 2'b10, 32'h3000_0020, 32'h0, 8'h0, "R5 postinc long");
    apply(2'b10, 2'b10, 32'hFFFF_FFFC, 32'h0, 8'h0, "R5 postinc long wrap");
    apply(2'b10, 2'b11, 32'h3000_0040, 32'h0, 8'h0, "R10 postinc rsvd size");
    idle(1);
    // R9 faulting post-increment
    apply(2'b10, 2'b01, 32'h3000_0011, 32'h0, 8'h0, "R9 postinc word odd");
    apply(2'b10, 2'b10, 32'h3000_0022, 32'h0, 8'h0, "R9 postinc long misaligned");
    apply(2'b01, 2'b10, 32'h3000_0030, 32'h0, 8'h0, "R11 indirect after post");
    // R6 / R7 PC-relative
    apply(2'b11, 2'b00, 32'h0, 32'h0000_1000, 8'hFF, "R6 pcrel byte");
    apply(2'b11, 2'b01, 32'h0, 32'h0000_1002, 8'h10, "R6 pcrel word");
    apply(2'b11, 2'b01, 32'h0, 32'h0000_1001, 8'h10, "R8 pcrel word odd pc");
    apply(2'b11, 2'b10, 32'h0, 32'h0000_1002, 8'h05, "R7 pcrel long round");
    apply(2'b11, 2'b10, 32'h0, 32'h0000_1000, 8'hFF, "R7 pcrel long max disp");
    apply(2'b11, 2'b11, 32'h0, 32'h0000_2006, 8'h01, "R10 pcrel rsvd size");
    apply(2'b10, 2'b01, 32'h4000_0000, 32'h0, 8'h0, "R5 postinc after pcrel");
    apply(2'b11, 2'b10, 32'h0, 32'h0000_0FFE, 8'h00, "R11 pcrel after post");
    idle(3);

    // R1: request during reset yields nothing, outputs cleared
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b1; mode = 2'b10; size = 2'b10; base = 32'h5555_5550;
    @(posedge clk);
    #1;
    check({ea_valid, reg_operand, addr_err, wb_en} === 4'b0 && ea === 0 && wb_data === 0,
          "R1 reset with request", ea, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b0;
    apply(2'b10, 2'b00, 32'h6000_0000, 32'h0, 8'h0, "R5 postinc after reset");
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule